// File: doc/BRIEF.md
# Host-to-IDE Write Steering Bridge

This block is the slave host-side front end of a local-bus disk controller. It watches host I/O cycles. It claims only those that fall in the register windows of two IDE channels. Each claimed cycle becomes one or two strobed transfers on a 16-bit IDE bus. The block picks the channel, the register offset and the data lane from the address and the active-low byte enables.

Data-port accesses with a word enable pattern move the low host word. A full double-word access is split into two IDE transfers, low word first. Single-byte writes take their data from a separate 8-bit host lane, and so do all accesses to command or control registers. That data appears on the low byte of the IDE bus.

Four strap inputs are sampled while reset is held. The values in place when reset is released are kept and presented on a configuration output. The enable strap gates all decoding. The host sees a one-clock ready pulse once the last IDE strobe of its access has ended.

Top module: `ide_host_bridge`

## Requirements
- R1: A cycle is claimed only when `hst_req`=1, `hst_mio`=0 and `hst_dc`=1. With `hst_wr`=1 the access pulses `ide_wr_n` low; with `hst_wr`=0 it pulses `ide_rd_n` low. The two strobes are never low together.
- R2: Addresses 1F0h–1F7h and 3F6h select channel 0 (`ide_cs_n`=2'b10). Addresses 170h–177h and 376h select channel 1 (`ide_cs_n`=2'b01). Exactly one select is low during a strobe.
- R3: Any other address, or a cycle with `hst_mio`=1 or `hst_dc`=0, causes no strobe, no select and no ready.
- R4: A write to the data port (offset 0) with `hst_be_n`=4'b1100 makes one IDE transfer carrying `hst_data[15:0]` on `ide_data`.
- R5: A data-port access with `hst_be_n`=4'b0000 makes two IDE transfers to offset 0 of the same channel. For a write, the first carries `hst_data[15:0]` and the second carries `hst_data[31:16]`.
- R6: A write with exactly one `hst_be_n` bit low drives `{8'h00, hst_sd}` on `ide_data` in a single transfer, including at the data port.
- R7: Accesses to offsets 1–7 and to 3F6h/376h use the 8-bit path: one transfer, `ide_data`={8'h00, `hst_sd`}, `ide_addr`=`hst_addr[2:0]`. `ide_ctl`=1 only for 3F6h/376h.
- R8: Each strobe is low for exactly STROBE_CLKS clocks. `ide_addr`, `ide_cs_n` and `ide_data` stay stable for the whole strobe.
- R9: `hst_rdy` is a single-clock pulse. It occurs once per claimed access, after the last strobe of that access has returned high.
- R10: While `rst_n` is low the straps are sampled. From reset release, `cfg_q` = {io_sel, ctl_en, acc_time[1:0], clk_rate[1:0]} holds the values sampled last, and later strap changes have no effect.
- R11: `rst_n` low ends any transfer at once: strobes go high, both selects go high, and no ready is given for the aborted access.
- R12: When the sampled controller-enable strap is 0, no cycle is decoded: no strobe and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset, asynchronous abort |
| strap_clk_rate | input | 2 | Host clock rate strap |
| strap_acc_time | input | 2 | Disk access time strap |
| strap_ctl_en | input | 1 | Controller enable strap |
| strap_io_sel | input | 1 | I/O select strap |
| cfg_q | output | 6 | Straps held since reset release |
| hst_req | input | 1 | One-clock cycle start from the host |
| hst_mio | input | 1 | Memory (1) or I/O (0) cycle |
| hst_dc | input | 1 | Data (1) or control (0) cycle |
| hst_wr | input | 1 | Write (1) or read (0) |
| hst_addr | input | 10 | Host I/O address |
| hst_be_n | input | 4 | Active-low byte enables |
| hst_data | input | 32 | Host data bus |
| hst_sd | input | 8 | 8-bit byte lane |
| hst_rdy | output | 1 | Access complete pulse |
| ide_cs_n | output | 2 | Channel selects, bit 0 = channel 0 |
| ide_ctl | output | 1 | Control-block register selected |
| ide_addr | output | 3 | IDE register offset |
| ide_data | output | 16 | IDE write data |
| ide_wr_n | output | 1 | IDE write strobe |
| ide_rd_n | output | 1 | IDE read strobe |

## Verification
Two events can fall in the same cycle: an assertion of reset and a live IDE strobe. The bench provokes this by starting a double-word write and pulling reset low while the second word's strobe is still low. It then requires that the strobe and both selects rise at once, and that no ready pulse follows. A second overlap is between the hand-over to the second word and the ready logic. That case is judged by requiring exactly two strobes of full width, with ready arriving only after the second one has ended.

// File: rtl/ide_br_pkg.sv
package ide_br_pkg;
  localparam int HA_W  = 10;
  localparam int HD_W  = 32;
  localparam int ID_W  = 16;
  localparam int SB_W  = 8;
  localparam int BE_W  = HD_W / 8;
  localparam int REG_W = 3;

  localparam logic [HA_W-1:0] CH0_BASE = 10'h1F0;
  localparam logic [HA_W-1:0] CH1_BASE = 10'h170;
  localparam logic [HA_W-1:0] CH0_CTL  = 10'h3F6;
  localparam logic [HA_W-1:0] CH1_CTL  = 10'h376;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STRB, ST_HOLD, ST_DONE} seq_state_e;

  typedef struct packed {
    logic       io_sel;
    logic       ctl_en;
    logic [1:0] acc_time;
    logic [1:0] clk_rate;
  } strap_t;

  typedef struct packed {
    logic             wr;
    logic             chan;
    logic             ctl;
    logic [REG_W-1:0] reg_ofs;
    logic             lane8;
    logic             dword;
    logic [HD_W-1:0]  hd;
    logic [SB_W-1:0]  sd;
  } xfer_t;

  function automatic logic in_block(input logic [HA_W-1:0] a, input logic [HA_W-1:0] base);
    return a[HA_W-1:REG_W] == base[HA_W-1:REG_W];
  endfunction

  function automatic logic is_ctl(input logic [HA_W-1:0] a);
    return (a == CH0_CTL) || (a == CH1_CTL);
  endfunction

  // bit 0: channel 0 window, bit 1: channel 1 window
  function automatic logic [1:0] chan_hit(input logic [HA_W-1:0] a);
    return {in_block(a, CH1_BASE) || (a == CH1_CTL),
            in_block(a, CH0_BASE) || (a == CH0_CTL)};
  endfunction

  function automatic logic single_byte(input logic [BE_W-1:0] be_n);
    logic [BE_W-1:0] on;
    on = ~be_n;
    return (on != '0) && ((on & (on - BE_W'(1))) == '0);
  endfunction

  function automatic logic use_lane8(input logic [HA_W-1:0] a, input logic [BE_W-1:0] be_n);
    return is_ctl(a) || (a[REG_W-1:0] != '0) || single_byte(be_n);
  endfunction

  function automatic logic is_dword(input logic [HA_W-1:0] a, input logic [BE_W-1:0] be_n);
    return !use_lane8(a, be_n) && (be_n == '0);
  endfunction

  function automatic logic [ID_W-1:0] steer(input logic [HD_W-1:0] hd, input logic [SB_W-1:0] sd,
                                            input logic lane8, input logic hi);
    if (lane8) return {{(ID_W-SB_W){1'b0}}, sd};
    return hi ? hd[HD_W-1:ID_W] : hd[ID_W-1:0];
  endfunction
endpackage

// File: rtl/ide_br_strap.sv
module ide_br_strap
  import ide_br_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t straps,
  output strap_t cfg
);
  // sampled every clock while reset is low; frozen from release onward
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= straps;
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg));
endmodule

// File: rtl/ide_br_decode.sv
module ide_br_decode
  import ide_br_pkg::*;
(
  input  logic            req,
  input  logic            mio,
  input  logic            dc,
  input  logic            wr,
  input  logic [HA_W-1:0] addr,
  input  logic [BE_W-1:0] be_n,
  input  logic [HD_W-1:0] hd,
  input  logic [SB_W-1:0] sd,
  input  logic            cfg_en,
  input  logic            idle,
  output logic            claim,
  output xfer_t           req_x
);
  logic [1:0] hit;

  always_comb begin
    hit           = chan_hit(addr);
    claim         = req && idle && cfg_en && !mio && dc && (hit != 2'b00);
    req_x.wr      = wr;
    req_x.chan    = hit[1];
    req_x.ctl     = is_ctl(addr);
    req_x.reg_ofs = addr[REG_W-1:0];
    req_x.lane8   = use_lane8(addr, be_n);
    req_x.dword   = is_dword(addr, be_n);
    req_x.hd      = hd;
    req_x.sd      = sd;
  end
endmodule

// File: rtl/ide_br_seq.sv
module ide_br_seq
  import ide_br_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  claim,
  input  logic  cfg_en,
  input  xfer_t req_x,
  output xfer_t act_x,
  output logic  busy,
  output logic  sel_on,
  output logic  strobe_on,
  output logic  word_hi,
  output logic  done
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          strobe_end;
  logic          second_due;

  assign strobe_end = (st == ST_STRB) && (cnt == LAST);
  assign second_due = act_x.dword && !word_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      word_hi <= 1'b0;
      act_x   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (claim) begin
          act_x   <= req_x;
          word_hi <= 1'b0;
          st      <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt <= '0;
          st  <= ST_STRB;
        end
        ST_STRB: begin
          if (strobe_end) st <= ST_HOLD;
          else            cnt <= cnt + CW'(1);
        end
        ST_HOLD: begin
          if (second_due) begin
            word_hi <= 1'b1;
            st      <= ST_SETUP;
          end else begin
            st <= ST_DONE;
          end
        end
        default: begin
          word_hi <= 1'b0;
          st      <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign sel_on    = (st == ST_SETUP) || (st == ST_STRB) || (st == ST_HOLD);
  assign strobe_on = (st == ST_STRB);
  assign done      = (st == ST_DONE);

  // checker-side width counter
  logic [CW:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wcnt <= '0;
    else if (strobe_on) wcnt <= wcnt + (CW+1)'(1);
    else                wcnt <= '0;
  end

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_on) |-> wcnt == (CW+1)'(STROBE_CLKS));
  // R9
  rdy_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st) == ST_HOLD);
  // R9
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && second_due) |=> (st == ST_SETUP && word_hi));
  // R12
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !cfg_en) |=> st == ST_IDLE);
endmodule

// File: rtl/ide_br_steer.sv
module ide_br_steer
  import ide_br_pkg::*;
(
  input  xfer_t           act_x,
  input  logic            word_hi,
  input  logic            drive,
  output logic [ID_W-1:0] data
);
  assign data = drive ? steer(act_x.hd, act_x.sd, act_x.lane8, word_hi) : '0;
endmodule

// File: rtl/ide_host_bridge.sv
module ide_host_bridge
  import ide_br_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_clk_rate,
  input  logic [1:0]  strap_acc_time,
  input  logic        strap_ctl_en,
  input  logic        strap_io_sel,
  output logic [5:0]  cfg_q,
  input  logic        hst_req,
  input  logic        hst_mio,
  input  logic        hst_dc,
  input  logic        hst_wr,
  input  logic [9:0]  hst_addr,
  input  logic [3:0]  hst_be_n,
  input  logic [31:0] hst_data,
  input  logic [7:0]  hst_sd,
  output logic        hst_rdy,
  output logic [1:0]  ide_cs_n,
  output logic        ide_ctl,
  output logic [2:0]  ide_addr,
  output logic [15:0] ide_data,
  output logic        ide_wr_n,
  output logic        ide_rd_n
);
  strap_t straps, cfg;
  xfer_t  req_x, act_x;
  logic   claim, busy, sel_on, strobe_on, word_hi, done;

  assign straps = '{io_sel: strap_io_sel, ctl_en: strap_ctl_en,
                    acc_time: strap_acc_time, clk_rate: strap_clk_rate};
  assign cfg_q  = cfg;

  ide_br_strap u_strap (.clk(clk), .rst_n(rst_n), .straps(straps), .cfg(cfg));

  ide_br_decode u_dec (
    .req(hst_req), .mio(hst_mio), .dc(hst_dc), .wr(hst_wr), .addr(hst_addr),
    .be_n(hst_be_n), .hd(hst_data), .sd(hst_sd), .cfg_en(cfg.ctl_en),
    .idle(!busy), .claim(claim), .req_x(req_x)
  );

  ide_br_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .claim(claim), .cfg_en(cfg.ctl_en), .req_x(req_x),
    .act_x(act_x), .busy(busy), .sel_on(sel_on), .strobe_on(strobe_on),
    .word_hi(word_hi), .done(done)
  );

  ide_br_steer u_steer (
    .act_x(act_x), .word_hi(word_hi), .drive(sel_on && act_x.wr), .data(ide_data)
  );

  assign ide_cs_n = sel_on ? ~(2'b01 << act_x.chan) : 2'b11;
  assign ide_ctl  = sel_on && act_x.ctl;
  assign ide_addr = sel_on ? act_x.reg_ofs : '0;
  assign ide_wr_n = !(strobe_on && act_x.wr);
  assign ide_rd_n = !(strobe_on && !act_x.wr);
  assign hst_rdy  = done;

  // R8
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> ($stable(ide_data) && $stable(ide_addr) && $stable(ide_cs_n)));
  // R2
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_wr_n || !ide_rd_n) |-> $onehot(~ide_cs_n));
  // R1
  strobe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_wr_n && !ide_rd_n));
  // R9
  rdy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rdy |-> (ide_wr_n && ide_rd_n && ide_cs_n == 2'b11));
endmodule

// File: tb/sim_ide_host_bridge.sv
module sim_ide_host_bridge;
  localparam int STB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_clk_rate = 2'd2;
  logic [1:0]  strap_acc_time = 2'd1;
  logic        strap_ctl_en = 1'b1;
  logic        strap_io_sel = 1'b0;
  logic [5:0]  cfg_q;
  logic        hst_req = 1'b0, hst_mio = 1'b0, hst_dc = 1'b1, hst_wr = 1'b1;
  logic [9:0]  hst_addr = '0;
  logic [3:0]  hst_be_n = 4'hF;
  logic [31:0] hst_data = '0;
  logic [7:0]  hst_sd = '0;
  logic        hst_rdy;
  logic [1:0]  ide_cs_n;
  logic        ide_ctl;
  logic [2:0]  ide_addr;
  logic [15:0] ide_data;
  logic        ide_wr_n, ide_rd_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ide_host_bridge #(.STROBE_CLKS(STB)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_clk_rate(strap_clk_rate), .strap_acc_time(strap_acc_time),
    .strap_ctl_en(strap_ctl_en), .strap_io_sel(strap_io_sel), .cfg_q(cfg_q),
    .hst_req(hst_req), .hst_mio(hst_mio), .hst_dc(hst_dc), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_be_n(hst_be_n), .hst_data(hst_data), .hst_sd(hst_sd),
    .hst_rdy(hst_rdy), .ide_cs_n(ide_cs_n), .ide_ctl(ide_ctl), .ide_addr(ide_addr),
    .ide_data(ide_data), .ide_wr_n(ide_wr_n), .ide_rd_n(ide_rd_n)
  );

  // strobe monitor, sampled on the falling edge
  int          pn, rdy_n, cyc, last_low, rdy_at;
  logic [15:0] pdata [4];
  logic [2:0]  paddr [4];
  logic [1:0]  pcs   [4];
  logic        pctl  [4];
  logic        pwr   [4];
  int          pw    [4];
  logic        prev_low = 1'b0;
  logic        mon_low;

  always @(negedge clk) begin
    cyc++;
    mon_low = !ide_wr_n || !ide_rd_n;
    if (mon_low) begin
      if (!prev_low) begin
        if (pn < 4) begin
          pdata[pn] = ide_data; paddr[pn] = ide_addr; pcs[pn] = ide_cs_n;
          pctl[pn] = ide_ctl;   pwr[pn] = !ide_wr_n;
        end
        pn++;
      end
      if (pn <= 4) pw[pn-1]++;
      last_low = cyc;
    end
    if (hst_rdy) begin rdy_n++; rdy_at = cyc; end
    prev_low = mon_low;
  end

  task automatic mon_clear();
    pn = 0; rdy_n = 0; last_low = 0; rdy_at = 0;
    for (int i = 0; i < 4; i++) pw[i] = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic [1:0] cr, input logic [1:0] at, input logic io);
    @(posedge clk); #2;
    rst_n = 1'b0; hst_req = 1'b0;
    strap_ctl_en = en; strap_clk_rate = cr; strap_acc_time = at; strap_io_sel = io;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic issue(input logic mio, input logic dc, input logic wr, input logic [9:0] a,
                       input logic [3:0] be, input logic [31:0] hd, input logic [7:0] sd);
    mon_clear();
    @(posedge clk); #2;
    hst_mio = mio; hst_dc = dc; hst_wr = wr; hst_addr = a; hst_be_n = be;
    hst_data = hd; hst_sd = sd; hst_req = 1'b1;
    @(posedge clk); #2 hst_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (rdy_n > 0) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic chk_pulse(input int i, input string tag, input logic [15:0] d, input logic [2:0] a,
                           input logic [1:0] cs, input logic ctl, input logic wr, input bit chk_data);
    if (chk_data) chk(pdata[i] == d, {tag, " data"}, pdata[i], d);
    chk(paddr[i] == a, {tag, " addr"}, paddr[i], a);
    chk(pcs[i] == cs, {tag, " cs"}, pcs[i], cs);
    chk(pctl[i] == ctl, {tag, " ctl"}, pctl[i], ctl);
    chk(pwr[i] == wr, {tag, " dir"}, pwr[i], wr);
    chk(pw[i] == STB, {tag, " R8 width"}, pw[i], STB);
  endtask

  task automatic chk_done(input string tag, input int exp_pulses);
    chk(pn == exp_pulses, {tag, " pulses"}, pn, exp_pulses);
    chk(rdy_n == 1, {tag, " R9 rdy count"}, rdy_n, 1);
    chk(rdy_at > last_low, {tag, " R9 rdy after strobe"}, rdy_at, last_low + 1);
  endtask

  task automatic t_reset_state();
    chk(ide_wr_n && ide_rd_n, "R11 reset strobes idle", {ide_wr_n, ide_rd_n}, 2'b11);
    chk(ide_cs_n == 2'b11, "R11 reset selects idle", ide_cs_n, 2'b11);
    chk(hst_rdy == 1'b0, "R9 reset rdy", hst_rdy, 0);
    chk(cfg_q == 6'b0_1_01_10, "R10 straps captured", cfg_q, 6'b0_1_01_10);
  endtask

  task automatic t_strap_hold();
    strap_clk_rate = 2'd1; strap_acc_time = 2'd3; strap_io_sel = 1'b1;
    repeat (3) @(posedge clk); #2;
    chk(cfg_q == 6'b0_1_01_10, "R10 straps frozen", cfg_q, 6'b0_1_01_10);
  endtask

  task automatic t_word_ch0();
    issue(0, 1, 1, 10'h1F0, 4'b1100, 32'hA5A5_1234, 8'h77);
    chk_done("R4 word", 1);
    chk_pulse(0, "R4 R2 word ch0", 16'h1234, 3'd0, 2'b10, 0, 1, 1);
  endtask

  task automatic t_dword_ch1();
    issue(0, 1, 1, 10'h170, 4'b0000, 32'hBEEF_C0DE, 8'h11);
    chk_done("R5 dword", 2);
    chk_pulse(0, "R5 low word", 16'hC0DE, 3'd0, 2'b01, 0, 1, 1);
    chk_pulse(1, "R5 high word", 16'hBEEF, 3'd0, 2'b01, 0, 1, 1);
  endtask

  task automatic t_byte_data_port();
    issue(0, 1, 1, 10'h1F0, 4'b1110, 32'h1111_2222, 8'h5C);
    chk_done("R6 byte", 1);
    chk_pulse(0, "R6 byte lane", 16'h005C, 3'd0, 2'b10, 0, 1, 1);
    issue(0, 1, 1, 10'h170, 4'b0111, 32'h3333_4444, 8'hE1);
    chk_done("R6 byte hi enable", 1);
    chk_pulse(0, "R6 byte lane be3", 16'h00E1, 3'd0, 2'b01, 0, 1, 1);
  endtask

  task automatic t_reg_paths();
    issue(0, 1, 1, 10'h1F3, 4'b1011, 32'hFFFF_FFFF, 8'h3A);
    chk_done("R7 reg byte", 1);
    chk_pulse(0, "R7 reg byte", 16'h003A, 3'd3, 2'b10, 0, 1, 1);
    issue(0, 1, 1, 10'h172, 4'b1100, 32'h0000_9876, 8'h4B);
    chk_done("R7 reg word", 1);
    chk_pulse(0, "R7 reg word via 8-bit", 16'h004B, 3'd2, 2'b01, 0, 1, 1);
    issue(0, 1, 1, 10'h376, 4'b1110, 32'h0, 8'h06);
    chk_done("R7 ctl reg", 1);
    chk_pulse(0, "R7 R2 ctl reg ch1", 16'h0006, 3'd6, 2'b01, 1, 1, 1);
    issue(0, 1, 1, 10'h3F6, 4'b1110, 32'h0, 8'h02);
    chk_pulse(0, "R7 R2 ctl reg ch0", 16'h0002, 3'd6, 2'b10, 1, 1, 1);
  endtask

  task automatic t_read();
    issue(0, 1, 0, 10'h1F7, 4'b1110, 32'h0, 8'h0);
    chk_done("R1 read", 1);
    chk_pulse(0, "R1 read strobe", 16'h0, 3'd7, 2'b10, 0, 0, 0);
    issue(0, 1, 0, 10'h170, 4'b0000, 32'h0, 8'h0);
    chk_done("R1 R5 dword read", 2);
    chk_pulse(1, "R1 R5 dword read 2nd", 16'h0, 3'd0, 2'b01, 0, 0, 0);
  endtask

  task automatic t_ignored();
    issue(0, 1, 1, 10'h1F8, 4'b1100, 32'h1, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R3 addr 1F8 ignored", pn + rdy_n, 0);
    issue(0, 1, 1, 10'h3F7, 4'b1110, 32'h1, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R3 addr 3F7 ignored", pn + rdy_n, 0);
    issue(0, 1, 1, 10'h16F, 4'b1110, 32'h1, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R3 addr 16F ignored", pn + rdy_n, 0);
    issue(1, 1, 1, 10'h1F0, 4'b1100, 32'h1, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R1 R3 memory cycle ignored", pn + rdy_n, 0);
    issue(0, 0, 1, 10'h1F0, 4'b1100, 32'h1, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R1 R3 control cycle ignored", pn + rdy_n, 0);
    chk(ide_cs_n == 2'b11, "R3 no select", ide_cs_n, 2'b11);
  endtask

  task automatic t_abort();
    mon_clear();
    @(posedge clk); #2;
    hst_mio = 0; hst_dc = 1; hst_wr = 1; hst_addr = 10'h1F0; hst_be_n = 4'b0000;
    hst_data = 32'h5555_AAAA; hst_req = 1'b1;
    @(posedge clk); #2 hst_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (pn >= 2) break;
      @(posedge clk);
    end
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk(ide_wr_n == 1'b1, "R11 abort strobe high", ide_wr_n, 1);
    chk(ide_cs_n == 2'b11, "R11 abort selects high", ide_cs_n, 2'b11);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (8) @(posedge clk);
    chk(rdy_n == 0, "R11 no rdy after abort", rdy_n, 0);
    chk(pn == 2, "R11 no strobe after abort", pn, 2);
  endtask

  task automatic t_disabled();
    do_reset(1'b0, 2'd3, 2'd0, 1'b1);
    chk(cfg_q == 6'b1_0_00_11, "R10 R12 disabled straps", cfg_q, 6'b1_0_00_11);
    issue(0, 1, 1, 10'h1F0, 4'b1100, 32'h1234, 8'h1);
    chk(pn == 0 && rdy_n == 0, "R12 disabled no decode", pn + rdy_n, 0);
    do_reset(1'b1, 2'd2, 2'd1, 1'b0);
    issue(0, 1, 1, 10'h1F0, 4'b1100, 32'h0000_0F0F, 8'h1);
    chk(pn == 1 && pdata[0] == 16'h0F0F, "R12 re-enabled decode", pdata[0], 16'h0F0F);
  endtask

  initial begin
    mon_clear();
    cyc = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    t_reset_state();
    t_strap_hold();
    t_word_ch0();
    t_dword_ch1();
    t_byte_data_port();
    t_reg_paths();
    t_read();
    t_ignored();
    t_abort();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule